// File: doc/BRIEF.md
# SDRAM Low-Power Mode Sequencer

This block takes the SDRAM command bus from the normal command path when the memory must sleep. It puts the device into self-refresh and brings it back out. It can also put the device into deep power-down, where refresh stops entirely. It drives the clock-enable pin and the three active-low command strobes. It reports an acknowledge that software or a power-management unit polls to learn that the device is actually asleep.

A self-refresh request comes from a register bit or from a power-management request line, and either one is enough. The sequencer first waits for the command path to report idle. It then precharges all banks and issues the auto-refresh that enters self-refresh, with clock-enable low in that same cycle. Only after that does the acknowledge go high. When the request drops, clock-enable rises, a programmable number of NOP cycles pass, and one auto-refresh is issued before control returns to the normal path.

Periodic refresh ticks are kept pending across a sleep transition, and they are still serviced while a soft reset holds off the normal command path. Static-memory requests are granted in every state, including while the SDRAM sleeps.

Top module: `sdram_lp_seq`

## Requirements
- R1: Command encoding is {ras_n, cas_n, we_n}: NOP 111, PRECHARGE-ALL 010, AUTO-REFRESH 001, BURST-TERMINATE 110. A software self-refresh request runs as follows:
  - The sequencer waits while `cmd_idle_i` is low.
  - It issues PRECHARGE-ALL with `cke_o` high.
  - In the next cycle it issues AUTO-REFRESH with `cke_o` low.
  - `sref_ack_o` goes high in the cycle after that.
- R2: The power-management request `pmu_sref_req_i` alone starts the same entry sequence as the software bit.
- R3: `cke_o` is low exactly from the entry cycle (AUTO-REFRESH or BURST-TERMINATE) until the exit begins. It is high in every other cycle, including during reset.
- R4: Deep power-down entry runs as follows:
  - The sequencer waits for `cmd_idle_i`.
  - It issues PRECHARGE-ALL.
  - It issues BURST-TERMINATE with `cke_o` low.
  - `dpd_ack_o` is high while the device stays down.
  - No AUTO-REFRESH is issued from the PRECHARGE-ALL cycle onward, and refresh ticks in that time are discarded.
- R5: When the deep-sleep bit drops, `cke_o` rises with a NOP for one cycle and `init_req_o` goes high in that cycle. `init_req_o` stays high until the cycle after `init_done_i` is sampled high.
- R6: While `soft_rst_i` is high, normal-path commands are replaced by NOP, but a refresh tick still produces an AUTO-REFRESH one cycle later.
- R7: `st_gnt_o` equals `st_req_i` delayed by one clock, in every state including self-refresh.
- R8: When every self-refresh request is withdrawn, the exit runs as follows:
  - `cke_o` rises with NOPs for `exit_cnt_i` cycles (a value of 0 acts as 1).
  - One AUTO-REFRESH follows with `sref_ack_o` still high.
  - `sref_ack_o` is low in the next cycle, and the normal path has the bus again.
- R9: Refresh ticks that arrive while a self-refresh transition or stay is in progress are held. They produce exactly one AUTO-REFRESH in the first normal-state cycle afterwards.
- R10: When self-refresh and deep-sleep are requested together, deep-sleep wins. A self-refresh request has no effect while the device is in deep power-down: `sref_ack_o` stays low and `dpd_ack_o` stays high.
- R11: In the normal state, a refresh tick produces AUTO-REFRESH in the next cycle. Otherwise `cmd_o` follows `norm_cmd_i`.
- R12: After hard reset the outputs are: `cke_o` high, both acknowledges low, `init_req_o` low, `st_gnt_o` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Hard reset, active low, asynchronous |
| soft_rst_i | input | 1 | Soft reset: suppresses normal-path commands only |
| sw_sref_req_i | input | 1 | Self-refresh request from the control register |
| pmu_sref_req_i | input | 1 | Self-refresh request from the power-management unit |
| deep_sleep_i | input | 1 | Deep power-down request |
| exit_cnt_i | input | EXIT_W | NOP cycles on self-refresh exit |
| cmd_idle_i | input | 1 | Normal command path is idle |
| ref_tick_i | input | 1 | Periodic refresh tick |
| norm_cmd_i | input | 3 | Command from the normal path |
| init_done_i | input | 1 | Re-initialization finished |
| st_req_i | input | 1 | Static-memory request |
| cke_o | output | 1 | SDRAM clock enable |
| cmd_o | output | 3 | {ras_n, cas_n, we_n} |
| sref_ack_o | output | 1 | Device is in self-refresh |
| dpd_ack_o | output | 1 | Device is in deep power-down |
| init_req_o | output | 1 | Device needs full re-initialization |
| st_gnt_o | output | 1 | Static-memory grant |

## Verification
A walked vector table runs three sleep cycles:
- a software-requested self-refresh with a late idle and refresh ticks inside the transition, which separates held ticks from dropped or duplicated ones;
- a power-management-requested self-refresh with idle already high, which shows that either source starts entry and that no stray refresh follows;
- a combined self-refresh and deep-sleep request with a tick during entry, which shows the priority and that ticks are discarded in power-down.

Directed tests then sweep the exit NOP count at 4 and at 0 to expose off-by-one counting. They also check refresh servicing under soft reset against plain passthrough, static grants while asleep, and the clearing of the re-initialization flag.

// File: rtl/sdram_lp_pkg.sv
`timescale 1ns/100ps
package sdram_lp_pkg;

  localparam int CMD_W = 3;

  // {ras_n, cas_n, we_n}
  localparam logic [CMD_W-1:0] CMD_NOP = 3'b111;
  localparam logic [CMD_W-1:0] CMD_PRE = 3'b010;
  localparam logic [CMD_W-1:0] CMD_REF = 3'b001;
  localparam logic [CMD_W-1:0] CMD_BST = 3'b110;

  typedef enum logic [3:0] {
    ST_ACTIVE   = 4'd0,
    ST_SR_WAIT  = 4'd1,
    ST_SR_PRE   = 4'd2,
    ST_SR_ENTER = 4'd3,
    ST_SR_HOLD  = 4'd4,
    ST_SR_XNOP  = 4'd5,
    ST_SR_XREF  = 4'd6,
    ST_DP_WAIT  = 4'd7,
    ST_DP_PRE   = 4'd8,
    ST_DP_ENTER = 4'd9,
    ST_DP_HOLD  = 4'd10,
    ST_DP_EXIT  = 4'd11
  } lp_state_e;

endpackage

// File: rtl/sdram_lp_exit_cnt.sv
`timescale 1ns/100ps
module sdram_lp_exit_cnt #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] val_i,
  input  logic         dec_i,
  output logic         last_o
);

  localparam logic [W-1:0] ONE = W'(1);

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (load_i) cnt_q <= val_i;
    else if (dec_i)  cnt_q <= cnt_q - ONE;
  end

  // zero behaves as one cycle
  assign last_o = (cnt_q <= ONE);

  // R8
  cnt_dec_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dec_i && !load_i) |=> (cnt_q == $past(cnt_q) - ONE));

endmodule

// File: rtl/sdram_lp_ref_pend.sv
`timescale 1ns/100ps
module sdram_lp_ref_pend (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic serve_i,
  input  logic drop_i,
  output logic pend_o
);

  logic pend_q;

  // only hard reset clears; soft reset never reaches here
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      pend_q <= 1'b0;
    else if (drop_i)  pend_q <= 1'b0;
    else if (tick_i)  pend_q <= 1'b1;
    else if (serve_i) pend_q <= 1'b0;
  end

  assign pend_o = pend_q;

  // R9
  tick_held_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && !drop_i) |=> pend_o);

  // R4
  tick_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    drop_i |=> !pend_o);

endmodule

// File: rtl/sdram_lp_fsm.sv
`timescale 1ns/100ps
module sdram_lp_fsm
  import sdram_lp_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      sref_req_i,
  input  logic      dp_req_i,
  input  logic      idle_i,
  input  logic      cnt_last_i,
  output lp_state_e state_o,
  output logic      cnt_load_o,
  output logic      cnt_dec_o,
  output logic      init_set_o
);

  lp_state_e st_q, st_d;

  always_comb begin
    st_d       = st_q;
    cnt_load_o = 1'b0;
    cnt_dec_o  = 1'b0;
    init_set_o = 1'b0;
    unique case (st_q)
      ST_ACTIVE: begin
        if (dp_req_i)        st_d = ST_DP_WAIT;
        else if (sref_req_i) st_d = ST_SR_WAIT;
      end
      ST_SR_WAIT: begin
        if (dp_req_i)         st_d = ST_DP_WAIT;
        else if (!sref_req_i) st_d = ST_ACTIVE;
        else if (idle_i)      st_d = ST_SR_PRE;
      end
      ST_SR_PRE:   st_d = ST_SR_ENTER;
      ST_SR_ENTER: st_d = ST_SR_HOLD;
      ST_SR_HOLD: begin
        if (!sref_req_i) begin
          st_d       = ST_SR_XNOP;
          cnt_load_o = 1'b1;
        end
      end
      ST_SR_XNOP: begin
        if (cnt_last_i) st_d = ST_SR_XREF;
        else            cnt_dec_o = 1'b1;
      end
      ST_SR_XREF: st_d = ST_ACTIVE;
      ST_DP_WAIT: begin
        if (!dp_req_i)   st_d = ST_ACTIVE;
        else if (idle_i) st_d = ST_DP_PRE;
      end
      ST_DP_PRE:   st_d = ST_DP_ENTER;
      ST_DP_ENTER: st_d = ST_DP_HOLD;
      ST_DP_HOLD: begin
        if (!dp_req_i) begin
          st_d       = ST_DP_EXIT;
          init_set_o = 1'b1;
        end
      end
      ST_DP_EXIT: st_d = ST_ACTIVE;
      default:    st_d = ST_ACTIVE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= ST_ACTIVE;
    else         st_q <= st_d;
  end

  assign state_o = st_q;

  // R10
  dp_priority_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_ACTIVE && dp_req_i) |=> (st_q == ST_DP_WAIT));

  // R10
  sref_ignored_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_DP_HOLD && dp_req_i) |=> (st_q == ST_DP_HOLD));

endmodule

// File: rtl/sdram_lp_seq.sv
`timescale 1ns/100ps
module sdram_lp_seq
  import sdram_lp_pkg::*;
#(
  parameter int EXIT_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              soft_rst_i,
  input  logic              sw_sref_req_i,
  input  logic              pmu_sref_req_i,
  input  logic              deep_sleep_i,
  input  logic [EXIT_W-1:0] exit_cnt_i,
  input  logic              cmd_idle_i,
  input  logic              ref_tick_i,
  input  logic [2:0]        norm_cmd_i,
  input  logic              init_done_i,
  input  logic              st_req_i,
  output logic              cke_o,
  output logic [2:0]        cmd_o,
  output logic              sref_ack_o,
  output logic              dpd_ack_o,
  output logic              init_req_o,
  output logic              st_gnt_o
);

  lp_state_e state;
  logic      sref_req;
  logic      cnt_load, cnt_dec, cnt_last, init_set;
  logic      pend, serve, drop;
  logic      init_q, gnt_q;
  logic [CMD_W-1:0] norm_gated;

  assign sref_req = sw_sref_req_i | pmu_sref_req_i;

  sdram_lp_fsm u_fsm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .sref_req_i (sref_req),
    .dp_req_i   (deep_sleep_i),
    .idle_i     (cmd_idle_i),
    .cnt_last_i (cnt_last),
    .state_o    (state),
    .cnt_load_o (cnt_load),
    .cnt_dec_o  (cnt_dec),
    .init_set_o (init_set)
  );

  sdram_lp_exit_cnt #(.W(EXIT_W)) u_exit_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (cnt_load),
    .val_i  (exit_cnt_i),
    .dec_i  (cnt_dec),
    .last_o (cnt_last)
  );

  assign serve = (state == ST_ACTIVE) && pend;
  assign drop  = (state == ST_DP_PRE) || (state == ST_DP_ENTER) ||
                 (state == ST_DP_HOLD) || (state == ST_DP_EXIT);

  sdram_lp_ref_pend u_ref_pend (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .tick_i  (ref_tick_i),
    .serve_i (serve),
    .drop_i  (drop),
    .pend_o  (pend)
  );

  assign norm_gated = soft_rst_i ? CMD_NOP : norm_cmd_i;

  always_comb begin
    unique case (state)
      ST_ACTIVE:               cmd_o = pend ? CMD_REF : norm_gated;
      ST_SR_WAIT, ST_DP_WAIT:  cmd_o = norm_gated;
      ST_SR_PRE, ST_DP_PRE:    cmd_o = CMD_PRE;
      ST_SR_ENTER, ST_SR_XREF: cmd_o = CMD_REF;
      ST_DP_ENTER:             cmd_o = CMD_BST;
      default:                 cmd_o = CMD_NOP;
    endcase
  end

  assign cke_o = !((state == ST_SR_ENTER) || (state == ST_SR_HOLD) ||
                   (state == ST_DP_ENTER) || (state == ST_DP_HOLD));

  assign sref_ack_o = (state == ST_SR_HOLD) || (state == ST_SR_XNOP) ||
                      (state == ST_SR_XREF);
  assign dpd_ack_o  = (state == ST_DP_HOLD);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      init_q <= 1'b0;
      gnt_q  <= 1'b0;
    end else begin
      gnt_q <= st_req_i;
      if (init_set)         init_q <= 1'b1;
      else if (init_done_i) init_q <= 1'b0;
    end
  end

  assign init_req_o = init_q;
  assign st_gnt_o   = gnt_q;

  // R1
  ack_after_entry_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sref_ack_o) |-> (!cke_o && $past(cmd_o) == CMD_REF));

  // R3
  cke_fall_cmd_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(cke_o) |-> (cmd_o == CMD_REF || cmd_o == CMD_BST));

  // R3
  cke_rise_nop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(cke_o) |-> (cmd_o == CMD_NOP));

  // R4
  dpd_no_ref_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dpd_ack_o |-> (cmd_o != CMD_REF && !cke_o));

  // R8
  ack_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(sref_ack_o) |-> (cke_o && $past(cmd_o) == CMD_REF));

  // R7
  st_grant_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    st_req_i |=> st_gnt_o);

  // R5
  init_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (init_req_o && !init_done_i) |=> init_req_o);

endmodule

// File: tb/sdram_lp_seq_tb.sv
`timescale 1ns/100ps
module sdram_lp_seq_tb_top;

  localparam int EXIT_W = 8;
  localparam int WD_CYC = 20000;

  logic              clk = 1'b0;
  logic              rst_ni = 1'b0;
  logic              soft_rst_i = 1'b0;
  logic              sw_sref_req_i = 1'b0;
  logic              pmu_sref_req_i = 1'b0;
  logic              deep_sleep_i = 1'b0;
  logic [EXIT_W-1:0] exit_cnt_i = 8'd2;
  logic              cmd_idle_i = 1'b0;
  logic              ref_tick_i = 1'b0;
  logic [2:0]        norm_cmd_i = 3'b111;
  logic              init_done_i = 1'b0;
  logic              st_req_i = 1'b0;
  logic              cke_o;
  logic [2:0]        cmd_o;
  logic              sref_ack_o, dpd_ack_o, init_req_o, st_gnt_o;

  int n_chk = 0;
  int n_bad = 0;
  int nop_n;
  logic done = 1'b0;

  always #2.5 clk = ~clk;

  sdram_lp_seq #(.EXIT_W(EXIT_W)) dut_i (
    .clk_i          (clk),
    .rst_ni         (rst_ni),
    .soft_rst_i     (soft_rst_i),
    .sw_sref_req_i  (sw_sref_req_i),
    .pmu_sref_req_i (pmu_sref_req_i),
    .deep_sleep_i   (deep_sleep_i),
    .exit_cnt_i     (exit_cnt_i),
    .cmd_idle_i     (cmd_idle_i),
    .ref_tick_i     (ref_tick_i),
    .norm_cmd_i     (norm_cmd_i),
    .init_done_i    (init_done_i),
    .st_req_i       (st_req_i),
    .cke_o          (cke_o),
    .cmd_o          (cmd_o),
    .sref_ack_o     (sref_ack_o),
    .dpd_ack_o      (dpd_ack_o),
    .init_req_o     (init_req_o),
    .st_gnt_o       (st_gnt_o)
  );

  // {sw, pmu, dp, idle, tick | cke, cmd[2:0], sref_ack, dpd_ack}
  localparam int NV = 29;
  localparam logic [10:0] VEC [0:NV-1] = '{
    11'b10000_1111_00, 11'b10000_1111_00, 11'b10011_1111_00,
    11'b10000_1010_00, 11'b10000_0001_00, 11'b10001_0111_10,
    11'b00000_0111_10, 11'b00000_1111_10, 11'b00000_1111_10,
    11'b00000_1001_10, 11'b00000_1001_00, 11'b00000_1111_00,
    11'b01010_1111_00, 11'b01010_1111_00, 11'b01010_1010_00,
    11'b01010_0001_00, 11'b00010_0111_10, 11'b00010_1111_10,
    11'b00010_1111_10, 11'b00010_1001_10, 11'b00010_1111_00,
    11'b10110_1111_00, 11'b10110_1111_00, 11'b10110_1010_00,
    11'b10111_0110_00, 11'b10110_0111_01, 11'b00010_0111_01,
    11'b00010_1111_00, 11'b00010_1111_00
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic cyc();
    @(negedge clk);
    #1;
  endtask

  initial begin
    #1;
    // R12 reset state
    chk("R12 cke", cke_o, 1);
    chk("R12 sref_ack", sref_ack_o, 0);
    chk("R12 dpd_ack", dpd_ack_o, 0);
    chk("R12 init_req", init_req_o, 0);
    chk("R12 st_gnt", st_gnt_o, 0);
    @(negedge clk);
    rst_ni = 1'b1;

    // R1 R8 R9 rows 0-11, R2 rows 12-20, R4 R10 R3 rows 21-28
    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      {sw_sref_req_i, pmu_sref_req_i, deep_sleep_i, cmd_idle_i, ref_tick_i} = VEC[i][10:6];
      #1;
      chk($sformatf("R1/R2/R3/R4/R8/R9/R10 row%0d cke", i), cke_o, VEC[i][5]);
      chk($sformatf("R1/R2/R4/R8/R9/R10 row%0d cmd", i), cmd_o, VEC[i][4:2]);
      chk($sformatf("R1/R8/R10 row%0d sref_ack", i), sref_ack_o, VEC[i][1]);
      chk($sformatf("R4/R10 row%0d dpd_ack", i), dpd_ack_o, VEC[i][0]);
    end
    {sw_sref_req_i, pmu_sref_req_i, deep_sleep_i, cmd_idle_i, ref_tick_i} = '0;

    // R5 re-init flag
    cyc(); chk("R5 init set", init_req_o, 1);
    @(negedge clk); init_done_i = 1'b1; #1; chk("R5 init before clear", init_req_o, 1);
    @(negedge clk); init_done_i = 1'b0; #1; chk("R5 init cleared", init_req_o, 0);

    // R11 refresh tick in normal state, passthrough otherwise
    @(negedge clk); norm_cmd_i = 3'b011; ref_tick_i = 1'b1; #1;
    chk("R11 passthrough", cmd_o, 3'b011);
    @(negedge clk); ref_tick_i = 1'b0; #1; chk("R11 tick ref", cmd_o, 3'b001);
    cyc(); chk("R11 back to norm", cmd_o, 3'b011);

    // R6 soft reset: normal path muted, refresh still issued
    @(negedge clk); soft_rst_i = 1'b1; #1; chk("R6 norm muted", cmd_o, 3'b111);
    @(negedge clk); ref_tick_i = 1'b1; #1; chk("R6 before ref", cmd_o, 3'b111);
    @(negedge clk); ref_tick_i = 1'b0; #1; chk("R6 ref in soft reset", cmd_o, 3'b001);
    cyc(); chk("R6 muted after ref", cmd_o, 3'b111);

    // R7 static grant across self-refresh
    @(negedge clk); soft_rst_i = 1'b0; norm_cmd_i = 3'b111; st_req_i = 1'b1; #1;
    chk("R7 grant lags", st_gnt_o, 0);
    @(negedge clk); sw_sref_req_i = 1'b1; cmd_idle_i = 1'b1;
    repeat (4) @(negedge clk);
    #1;
    chk("R1 ack in sref", sref_ack_o, 1);
    chk("R3 cke low in sref", cke_o, 0);
    chk("R7 grant in sref", st_gnt_o, 1);
    @(negedge clk); st_req_i = 1'b0; #1; chk("R7 grant held one cycle", st_gnt_o, 1);
    cyc(); chk("R7 grant drops", st_gnt_o, 0);

    // R8 exit with 4 NOP cycles
    @(negedge clk); sw_sref_req_i = 1'b0; exit_cnt_i = 8'd4; #1;
    nop_n = 0;
    for (int k = 0; k < 20; k++) begin
      cyc();
      if (cmd_o == 3'b001) break;
      if (cke_o && cmd_o == 3'b111) nop_n++;
    end
    chk("R8 nop count 4", nop_n, 4);
    chk("R8 ack during exit ref", sref_ack_o, 1);
    cyc(); chk("R8 ack cleared", sref_ack_o, 0);

    // R8 exit count 0 acts as 1
    @(negedge clk); pmu_sref_req_i = 1'b1;
    repeat (4) @(negedge clk);
    #1; chk("R2 ack via pmu", sref_ack_o, 1);
    @(negedge clk); pmu_sref_req_i = 1'b0; exit_cnt_i = 8'd0; #1;
    nop_n = 0;
    for (int k = 0; k < 20; k++) begin
      cyc();
      if (cmd_o == 3'b001) break;
      if (cke_o && cmd_o == 3'b111) nop_n++;
    end
    chk("R8 nop count 0->1", nop_n, 1);
    cyc(); chk("R8 ack cleared 2", sref_ack_o, 0);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (WD_CYC) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL all watchdog act=%0d exp=done", WD_CYC);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

endmodule